// File: doc/BRIEF.md
# Six-Channel PWM Generator with Lead-In Delay

This block generates six independent pulse-width modulated outputs from one input clock. Software programs it through a plain word-addressed register interface: one write strobe, a word address, write data and a read data bus that reflects the addressed register in the same cycle. Each channel owns two registers. The control register holds an enable flag, a lead-in delay and a repeat limit. The timing register holds the length of the high phase and the length of the low phase, both counted in input clock cycles.

When a channel is enabled it keeps its output low for the programmed lead-in time. It then emits periods made of a high phase followed by a low phase. The periods repeat either a fixed number of times or without end. Timing values written while a channel runs are held back until the current period ends, so no period is ever cut short or stretched by a rewrite. Clearing the enable flag, by contrast, forces the output low straight away, in the middle of a period if need be. Each channel works from a private working copy of its timing values, taken at every period start.

Top module: `pwm_leadin_array`

## Requirements
- R1: After reset every register reads 0 and all six outputs are low.
- R2: Word address bit 3 selects the bank (0 = control, 1 = timing) and bits 2:0 select the channel, so control of channel n sits at word n (byte 4n) and timing at word 8+n (byte 0x20+4n). Registers read back the last value written. Words 6, 7, 14 and 15 read 0 and ignore writes.
- R3: Control bit 31 is the enable and bits 30:16 the lead-in length L. The write that sets the enable from 0 is followed by one low cycle, then L further low cycles, then the first high phase.
- R4: Timing bits 31:16 give the high length H and bits 15:0 the low length W. Each period drives H high cycles first, then W low cycles, and periods follow back to back.
- R5: H = 0 gives an all-low period of W cycles. W = 0 gives an all-high period of H cycles. H = W = 0 gives a one-cycle low period.
- R6: Control bits 15:0 set the repeat limit N. With N > 0 the channel emits exactly N periods and then holds its output low for as long as the enable stays set. N = 0 repeats without end.
- R7: A timing write during a running period leaves that period unchanged. The new values take effect from the next period start, and also at the first period after the lead-in.
- R8: Clearing the enable drives the output low in the cycle right after the write edge, even in the middle of a high phase.
- R9: Enabling again after a disable restarts the channel from the lead-in, using the register values in force at that moment. This applies to a channel that was running and to one that had used up its repeat limit.
- R10: The lead-in and the repeat limit are captured when the channel starts. A control write that keeps the enable set neither restarts the channel nor changes the captured values.
- R11: Channels are independent. Activity on one channel never alters the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; every counted cycle is one period of this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Word address: bit 3 selects the bank, bits 2:0 select the channel |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Contents of the addressed register, valid in the same cycle |
| pwm_out | output | 6 | One waveform output per channel |

## Verification
The bench aims at the period boundaries. It rewrites the timing register halfway through a period and checks that the current period finishes on the old values. A design that loaded the new values at once would bend the edge of that period. The bench also drops the enable while the output is high, which exposes a design that finishes the period before stopping. It exercises zero-length high and low phases and the case where both are zero: an off-by-one in the period length would show up there as a stuck or extra high cycle. Finally it lets a finite repeat limit run out and then writes the control register without touching the enable. A design that counted one period too many or too few, or that restarted on any control write, would produce a different edge sequence from the cycle-by-cycle model.

// File: rtl/pwm_lead_pkg.sv
package pwm_lead_pkg;
  localparam int DATA_W = 32;
  localparam int TIME_W = 16;
  localparam int LEAD_W = 15;
  localparam int REP_W  = 16;
  localparam int PER_W  = TIME_W + 1;
  localparam int EN_BIT = 31;

  typedef enum logic [1:0] {ST_OFF, ST_LEAD, ST_RUN, ST_DONE} chan_st_e;

  function automatic logic en_flag(input logic [DATA_W-1:0] w);
    return w[EN_BIT];
  endfunction

  function automatic logic [LEAD_W-1:0] lead_time(input logic [DATA_W-1:0] w);
    return w[EN_BIT-1 -: LEAD_W];
  endfunction

  function automatic logic [REP_W-1:0] rep_limit(input logic [DATA_W-1:0] w);
    return w[REP_W-1:0];
  endfunction

  function automatic logic [TIME_W-1:0] hi_time(input logic [DATA_W-1:0] w);
    return w[DATA_W-1 -: TIME_W];
  endfunction

  function automatic logic [TIME_W-1:0] lo_time(input logic [DATA_W-1:0] w);
    return w[TIME_W-1:0];
  endfunction

  // Period length in cycles; an all-zero setting still lasts one cycle.
  function automatic logic [PER_W-1:0] period_len(input logic [DATA_W-1:0] w);
    logic [PER_W-1:0] s;
    s = PER_W'(hi_time(w)) + PER_W'(lo_time(w));
    return (s == '0) ? PER_W'(1) : s;
  endfunction
endpackage

// File: rtl/pwm_lead_regs.sv
module pwm_lead_regs
  import pwm_lead_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [AW-1:0]                addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata,
  output logic [NCH-1:0][DATA_W-1:0]   ctl_q,
  output logic [NCH-1:0][DATA_W-1:0]   tim_q
);
  localparam int IDX_W = AW - 1;

  logic             bank_tim;
  logic [IDX_W-1:0] idx;

  assign bank_tim = addr[AW-1];
  assign idx      = addr[IDX_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_q[g] <= '0;
        tim_q[g] <= '0;
      end else if (wr && idx == IDX_W'(g)) begin
        if (bank_tim) tim_q[g] <= wdata;
        else          ctl_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (idx == IDX_W'(k)) rdata = bank_tim ? tim_q[k] : ctl_q[k];
    end
  end
endmodule

// File: rtl/pwm_lead_chan.sv
module pwm_lead_chan
  import pwm_lead_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ctl,
  input  logic [DATA_W-1:0] tim,
  output logic              out,
  output chan_st_e          st_o,
  output logic [PER_W-1:0]  pos_o,
  output logic [PER_W-1:0]  per_o,
  output logic [DATA_W-1:0] sh_o,
  output logic              wrap_o
);
  chan_st_e          st;
  logic [PER_W-1:0]  pos;
  logic [DATA_W-1:0] sh;
  logic [LEAD_W-1:0] lcnt;
  logic [REP_W-1:0]  rlim;
  logic [REP_W-1:0]  rcnt;

  logic              en;
  logic [PER_W-1:0]  per;
  logic              at_end;
  logic              last_rep;

  assign en       = en_flag(ctl);
  assign per      = period_len(sh);
  assign at_end   = (pos == per - PER_W'(1));
  assign last_rep = (rlim != '0) && (rcnt == rlim - REP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      pos  <= '0;
      sh   <= '0;
      lcnt <= '0;
      rlim <= '0;
      rcnt <= '0;
    end else if (!en) begin
      st <= ST_OFF;
    end else begin
      unique case (st)
        ST_OFF: begin
          sh   <= tim;
          rlim <= rep_limit(ctl);
          rcnt <= '0;
          pos  <= '0;
          lcnt <= lead_time(ctl);
          st   <= (lead_time(ctl) == '0) ? ST_RUN : ST_LEAD;
        end
        ST_LEAD: begin
          if (lcnt == LEAD_W'(1)) begin
            st  <= ST_RUN;
            pos <= '0;
            sh  <= tim;
          end else begin
            lcnt <= lcnt - LEAD_W'(1);
          end
        end
        ST_RUN: begin
          if (at_end) begin
            if (last_rep) begin
              st <= ST_DONE;
            end else begin
              pos <= '0;
              sh  <= tim;
              if (rlim != '0) rcnt <= rcnt + REP_W'(1);
            end
          end else begin
            pos <= pos + PER_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign out    = en && (st == ST_RUN) && (pos < PER_W'(hi_time(sh)));
  assign wrap_o = en && (st == ST_RUN) && at_end;
  assign st_o   = st;
  assign pos_o  = pos;
  assign per_o  = per;
  assign sh_o   = sh;
endmodule

// File: rtl/pwm_leadin_array.sv
module pwm_leadin_array
  import pwm_lead_pkg::*;
#(
  parameter int NCH = 6,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [NCH-1:0][DATA_W-1:0] ctl_q;
  logic [NCH-1:0][DATA_W-1:0] tim_q;

  // Named per-channel events for the checker.
  logic [NCH-1:0]             ch_en;
  logic [NCH-1:0]             ch_lead;
  logic [NCH-1:0]             ch_run;
  logic [NCH-1:0]             ch_done;
  logic [NCH-1:0]             ch_wrap;
  logic [NCH-1:0][PER_W-1:0]  ch_pos;
  logic [NCH-1:0][PER_W-1:0]  ch_per;
  logic [NCH-1:0][DATA_W-1:0] ch_sh;

  pwm_lead_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .ctl_q (ctl_q),
    .tim_q (tim_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_st_e st;

    pwm_lead_chan u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl_q[g]),
      .tim    (tim_q[g]),
      .out    (pwm_out[g]),
      .st_o   (st),
      .pos_o  (ch_pos[g]),
      .per_o  (ch_per[g]),
      .sh_o   (ch_sh[g]),
      .wrap_o (ch_wrap[g])
    );

    assign ch_en[g]   = en_flag(ctl_q[g]);
    assign ch_lead[g] = (st == ST_LEAD);
    assign ch_run[g]  = (st == ST_RUN);
    assign ch_done[g] = (st == ST_DONE);
  end
endmodule

// File: rtl/pwm_leadin_array_chk.sv
module pwm_leadin_array_chk
  import pwm_lead_pkg::*;
#(
  parameter int NCH = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NCH-1:0]               pwm_out,
  input logic [NCH-1:0]               ch_en,
  input logic [NCH-1:0]               ch_lead,
  input logic [NCH-1:0]               ch_run,
  input logic [NCH-1:0]               ch_done,
  input logic [NCH-1:0]               ch_wrap,
  input logic [NCH-1:0][PER_W-1:0]    ch_pos,
  input logic [NCH-1:0][PER_W-1:0]    ch_per,
  input logic [NCH-1:0][DATA_W-1:0]   ch_sh
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |-> !pwm_out[g]);

    p_lead_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_lead[g] |-> !pwm_out[g]);

    p_high_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[g] |-> ch_run[g]);

    p_pos_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ch_run[g] |-> (ch_pos[g] < ch_per[g]));

    p_zero_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[g] && hi_time(ch_sh[g]) == '0) |-> !pwm_out[g]);

    p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_done[g] && ch_en[g]) |=> ch_done[g]);

    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_run[g] && !ch_wrap[g]) |=> $stable(ch_sh[g]));
  end
endmodule

bind pwm_leadin_array pwm_leadin_array_chk #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_out (pwm_out),
  .ch_en   (ch_en),
  .ch_lead (ch_lead),
  .ch_run  (ch_run),
  .ch_done (ch_done),
  .ch_wrap (ch_wrap),
  .ch_pos  (ch_pos),
  .ch_per  (ch_per),
  .ch_sh   (ch_sh)
);

// File: tb/sim_pwm_leadin_array.sv
module sim_pwm_leadin_array;
  localparam int NCH = 6;
  localparam logic [31:0] EN = 32'h8000_0000;
  localparam int M_OFF = 0, M_LEAD = 1, M_HI = 2, M_LO = 3, M_DONE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire  [5:0]  pwm_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    run_done = 1'b0;

  // Reference model state
  int          mst [NCH];
  int          mrem[NCH];
  int          mlo [NCH];
  int          mrep[NCH];
  int          mcnt[NCH];
  logic [31:0] mctl[NCH];
  logic [31:0] mtim[NCH];

  always #10 clk = ~clk;

  pwm_leadin_array u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  function automatic void begin_period(int c);
    int h;
    h      = int'(mtim[c][31:16]);
    mlo[c] = int'(mtim[c][15:0]);
    if (h > 0) begin
      mst[c] = M_HI; mrem[c] = h;
    end else if (mlo[c] > 0) begin
      mst[c] = M_LO; mrem[c] = mlo[c];
    end else begin
      mst[c] = M_LO; mrem[c] = 1;
    end
  endfunction

  function automatic void end_period(int c);
    mcnt[c] = mcnt[c] + 1;
    if (mrep[c] != 0 && mcnt[c] >= mrep[c]) mst[c] = M_DONE;
    else begin_period(c);
  endfunction

  function automatic void step(int c);
    if (!mctl[c][31]) begin
      mst[c] = M_OFF;
    end else begin
      case (mst[c])
        M_OFF: begin
          mrep[c] = int'(mctl[c][15:0]);
          mcnt[c] = 0;
          if (mctl[c][30:16] != 0) begin
            mst[c] = M_LEAD; mrem[c] = int'(mctl[c][30:16]);
          end else begin
            begin_period(c);
          end
        end
        M_LEAD: begin
          mrem[c] = mrem[c] - 1;
          if (mrem[c] == 0) begin_period(c);
        end
        M_HI: begin
          mrem[c] = mrem[c] - 1;
          if (mrem[c] == 0) begin
            if (mlo[c] > 0) begin
              mst[c] = M_LO; mrem[c] = mlo[c];
            end else begin
              end_period(c);
            end
          end
        end
        M_LO: begin
          mrem[c] = mrem[c] - 1;
          if (mrem[c] == 0) end_period(c);
        end
        default: ;
      endcase
    end
  endfunction

  function automatic logic [5:0] expected_out();
    logic [5:0] e;
    for (int c = 0; c < NCH; c++) e[c] = mctl[c][31] && (mst[c] == M_HI);
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        mst[c] = M_OFF; mrem[c] = 0; mlo[c] = 0; mrep[c] = 0; mcnt[c] = 0;
        mctl[c] = '0; mtim[c] = '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) step(c);
      if (bus_wr && bus_addr[2:0] < 3'd6) begin
        if (bus_addr[3]) mtim[bus_addr[2:0]] = bus_wdata;
        else             mctl[bus_addr[2:0]] = bus_wdata;
      end
    end
  end

  // Per-cycle comparison of all outputs against the model.
  always @(negedge clk) begin
    if (rst_n && !run_done) begin
      checks++;
      if (pwm_out !== expected_out()) begin
        errors++;
        $display("FAIL %s waveform at %0t: actual %b expected %b",
                 cur_req, $time, pwm_out, expected_out());
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(bus_rdata, exp, $sformatf("readback word %0d", a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_high(input int c);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwm_out[c]) break;
    end
  endtask

  task automatic finish_run();
    run_done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    cur_req = "R1";
    for (int a = 0; a < 16; a++) rd_chk(4'(a), 32'h0);
    chk({26'h0, pwm_out}, 32'h0, "outputs after reset");

    // R2: address map and readback
    cur_req = "R2";
    wr(4'd1, 32'h0012_3456);
    wr(4'd11, 32'hABCD_0123);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_chk(4'd1, 32'h0012_3456);
    rd_chk(4'd11, 32'hABCD_0123);
    rd_chk(4'd6, 32'h0);
    rd_chk(4'd15, 32'h0);
    rd_chk(4'd3, 32'h0);
    chk({26'h0, pwm_out}, 32'h0, "no output while disabled");
    wr(4'd1, 32'h0);
    wr(4'd11, 32'h0);

    // R3 / R4: lead-in then high-first periods
    cur_req = "R3";
    wr(4'd8, {16'd3, 16'd2});
    wr(4'd0, EN | (32'd4 << 16));
    idle(6);
    cur_req = "R4";
    idle(30);

    // R5: zero-length phases
    cur_req = "R5";
    wr(4'd9, {16'd0, 16'd5});
    wr(4'd10, {16'd4, 16'd0});
    wr(4'd11, 32'h0);
    wr(4'd1, EN);
    wr(4'd2, EN | (32'd2 << 16));
    wr(4'd3, EN);
    idle(30);
    chk({31'h0, pwm_out[1]}, 32'h0, "high=0 stays low");
    chk({31'h0, pwm_out[2]}, 32'h1, "low=0 stays high");
    chk({31'h0, pwm_out[3]}, 32'h0, "both zero stays low");

    // R6: finite repeat count
    cur_req = "R6";
    wr(4'd12, {16'd2, 16'd3});
    wr(4'd4, EN | (32'd1 << 16) | 32'd3);
    idle(40);
    chk({31'h0, pwm_out[4]}, 32'h0, "low after repeat limit");

    // R10: control rewrite with enable held
    cur_req = "R10";
    wr(4'd4, EN | (32'd7 << 16) | 32'd9);
    idle(20);
    chk({31'h0, pwm_out[4]}, 32'h0, "no restart on control rewrite");
    wr(4'd0, EN | (32'd20 << 16));
    idle(20);

    // R7: timing updates take effect at period boundary
    cur_req = "R7";
    wr(4'd8, {16'd1, 16'd1});
    idle(20);
    wait_high(0);
    wr(4'd8, {16'd5, 16'd7});
    idle(30);

    // R8: immediate disable in the middle of a high phase
    cur_req = "R8";
    wait_high(0);
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({31'h0, pwm_out[0]}, 32'h0, "ch0 low right after disable");
    bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h0;
    @(negedge clk);
    bus_wr = 1'b0;
    chk({31'h0, pwm_out[2]}, 32'h0, "ch2 low right after disable");
    idle(5);

    // R9: restart after repeat exhaustion and after disable
    cur_req = "R9";
    wr(4'd4, 32'h0);
    wr(4'd4, EN | (32'd2 << 16) | 32'd1);
    idle(20);
    wr(4'd0, EN | (32'd3 << 16) | 32'd2);
    idle(40);
    chk({31'h0, pwm_out[0]}, 32'h0, "ch0 idle after two periods");

    // R11: all channels with distinct settings at once
    cur_req = "R11";
    wr(4'd13, {16'd1, 16'd4});
    wr(4'd5, EN | (32'd5 << 16));
    wr(4'd8, {16'd2, 16'd2});
    wr(4'd0, 32'h0);
    wr(4'd0, EN);
    wr(4'd10, {16'd3, 16'd1});
    wr(4'd2, EN | (32'd1 << 16) | 32'd4);
    idle(60);
    wr(4'd5, 32'h0);
    idle(10);

    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!run_done) begin
      errors++;
      $display("FAIL %s watchdog expired: actual running expected finished", cur_req);
      finish_run();
    end
  end
endmodule